// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block runs the hardware part of taking and leaving an interrupt for a CPU pipeline. Each interrupt belongs to one of two classes. A normal interrupt pushes the interrupted PSW and PC onto the memory stack as two 32-bit words. A fast interrupt copies both values into one pair of backup registers in a single step and touches no memory. The matching return command reverses the save: the normal return reads both words back from the stack, and the fast return takes them from the backup pair. Each path has a fixed latency of its own. Normal entry takes 7 clocks and fast entry 5. Normal return takes 6 clocks and fast return 3.

The pipeline supplies the live PC, PSW and stack pointer, plus the handler address found by an external vector lookup. It stalls while `busy` is high. In the last busy cycle it takes the new PC, PSW and, for stack operations, the new stack pointer from one-cycle load strobes. Firmware saves general registers when it needs to. The interrupt enable flag is a bit of the live PSW. On entry the sequencer clears it in the PSW it hands back, and the PSW restored on return brings back whatever was saved.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, and in every cycle with no operation running, `busy`, `memWrEn`, `memRdEn`, `pcLoad`, `pswLoad` and `spLoad` are low.
- R2: An interrupt request is taken only at a clock edge that ends a cycle with `busy` low, `irqReq` high and bit 16 of `curPsw` set. Otherwise it has no effect. A request still held high when `busy` falls is taken at the first such edge.
- R3: A normal entry holds `busy` for 7 cycles, starting the cycle after acceptance. In busy cycle 1 it writes the captured PSW to SP-4, and in cycle 2 it writes the captured PC to SP-8. Here SP is `spIn` at acceptance. In cycle 7 it loads PC with `vecPc` and SP with SP-8.
- R4: A fast entry holds `busy` for 5 cycles and makes no memory request. In cycle 5 it loads PC with `vecPc` and leaves SP unloaded. The PC and PSW at acceptance are kept for the fast return.
- R5: In the last cycle of either entry, `pswLoad` is high and `pswOut` equals the PSW captured at acceptance with bit 16 cleared.
- R6: After a fast entry and until its fast return completes, a fast request is refused and stays pending. A normal request is still taken.
- R7: A normal return (`retNormal` in an idle cycle) holds `busy` for 6 cycles. It reads SP in cycle 1 and SP+4 in cycle 2, and each word arrives on `memRdData` in the cycle after its read. In cycle 6 it loads PC with the first word, PSW with the second word, and SP with SP+8.
- R8: A fast return (`retFast` in an idle cycle while the backup pair is occupied) holds `busy` for 3 cycles and makes no memory request. In cycle 3 it loads PC and PSW from the backup pair and frees the pair. `retFast` with the pair empty is ignored.
- R9: When several commands arrive in one idle cycle, a valid fast return wins over a normal return, and a normal return wins over an interrupt request. The losing request is not taken.
- R10: Return commands and interrupt requests that arrive while `busy` is high are discarded and start no later operation on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Interrupt request, level |
| irqFast | input | 1 | Class of the request: 1 fast, 0 normal |
| vecPc | input | 32 | Handler address from the vector lookup |
| curPc | input | 32 | Live PC of the interrupted program |
| curPsw | input | 32 | Live PSW; bit 16 is the interrupt enable |
| spIn | input | 32 | Live stack pointer |
| retNormal | input | 1 | Return-from-normal-interrupt command pulse |
| retFast | input | 1 | Return-from-fast-interrupt command pulse |
| memWrEn | output | 1 | Stack write request |
| memRdEn | output | 1 | Stack read request |
| memAddr | output | 32 | Byte address of the stack access |
| memWrData | output | 32 | Word to be written |
| memRdData | input | 32 | Read word, valid the cycle after memRdEn |
| pcLoad | output | 1 | Load pcOut into the pipeline PC |
| pcOut | output | 32 | Redirected PC |
| pswLoad | output | 1 | Load pswOut into the live PSW |
| pswOut | output | 32 | New PSW |
| spLoad | output | 1 | Load spOut into the stack pointer |
| spOut | output | 32 | New stack pointer |
| busy | output | 1 | Sequencer active; pipeline stalls |

## Verification
A wrong step counter or a wrong operation state would move the load strobes or the fall of `busy` by at least one cycle, and the per-cycle comparison flags this in the same cycle. A wrong stack offset or a swapped push order appears on `memAddr` or `memWrData` in the first two busy cycles of an entry. A backup pair that holds the wrong values, or a stale occupied flag, appears only later. It shows as wrong PC and PSW values at the next fast return, or as a fast request that is accepted or refused when it should not be. The bench therefore pairs each fast entry with a return and with a blocked-request window.

// File: rtl/irq_ctx_seq_pkg.sv
package irq_ctx_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ENT_N,
    OP_ENT_F,
    OP_RET_N,
    OP_RET_F
  } seqOpE;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;   // latch live context and handler
    logic saveBk;   // copy live PC/PSW into backup pair
    logic wrPsw;    // push PSW word
    logic wrPc;     // push PC word
    logic rdPc;     // pop PC word
    logic rdPsw;    // pop PSW word
    logic capPc;    // capture returning PC word
    logic capPsw;   // capture returning PSW word
    logic finEntN;  // final cycle of normal entry
    logic finEntF;  // final cycle of fast entry
    logic finRetN;  // final cycle of normal return
    logic finRetF;  // final cycle of fast return
  } seqStrobeS;

endpackage

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_seq_pkg::*;
#(
  parameter int ENT_N_CYC = 7,  // needs >= 2
  parameter int ENT_F_CYC = 5,  // needs >= 1
  parameter int RET_N_CYC = 6,  // needs >= 4
  parameter int RET_F_CYC = 3   // needs >= 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqReq,
  input  logic      irqFast,
  input  logic      irqEnable,
  input  logic      retNormal,
  input  logic      retFast,
  output seqStrobeS strb,
  output logic      busy
);

  localparam int MAX_AB  = (ENT_N_CYC > ENT_F_CYC) ? ENT_N_CYC : ENT_F_CYC;
  localparam int MAX_CD  = (RET_N_CYC > RET_F_CYC) ? RET_N_CYC : RET_F_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int STEP_W  = $clog2(MAX_CYC + 1);

  seqOpE             op;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] opLast;
  logic              bkFull;
  logic              idle, lastStep, goIrq;
  logic              goEntN, goEntF, goRetN, goRetF;

  always_comb begin
    idle   = (op == OP_IDLE);
    goRetF = idle && retFast && bkFull;
    goRetN = idle && retNormal && !goRetF;
    goIrq  = idle && irqReq && irqEnable && !goRetF && !retNormal;
    goEntF = goIrq && irqFast && !bkFull;
    goEntN = goIrq && !irqFast;
  end

  always_comb begin
    case (op)
      OP_ENT_N: opLast = STEP_W'(ENT_N_CYC - 1);
      OP_ENT_F: opLast = STEP_W'(ENT_F_CYC - 1);
      OP_RET_N: opLast = STEP_W'(RET_N_CYC - 1);
      OP_RET_F: opLast = STEP_W'(RET_F_CYC - 1);
      default:  opLast = '0;
    endcase
    lastStep = !idle && (step == opLast);
  end

  always_comb begin
    strb         = '0;
    strb.accept  = goEntN || goEntF || goRetN || goRetF;
    strb.saveBk  = goEntF;
    strb.wrPsw   = (op == OP_ENT_N) && (step == STEP_W'(0));
    strb.wrPc    = (op == OP_ENT_N) && (step == STEP_W'(1));
    strb.rdPc    = (op == OP_RET_N) && (step == STEP_W'(0));
    strb.rdPsw   = (op == OP_RET_N) && (step == STEP_W'(1));
    strb.capPc   = (op == OP_RET_N) && (step == STEP_W'(1));
    strb.capPsw  = (op == OP_RET_N) && (step == STEP_W'(2));
    strb.finEntN = (op == OP_ENT_N) && lastStep;
    strb.finEntF = (op == OP_ENT_F) && lastStep;
    strb.finRetN = (op == OP_RET_N) && lastStep;
    strb.finRetF = (op == OP_RET_F) && lastStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op     <= OP_IDLE;
      step   <= '0;
      bkFull <= 1'b0;
    end else begin
      if (idle) begin
        step <= '0;
        if (goRetF)      op <= OP_RET_F;
        else if (goRetN) op <= OP_RET_N;
        else if (goEntF) op <= OP_ENT_F;
        else if (goEntN) op <= OP_ENT_N;
      end else if (lastStep) begin
        op   <= OP_IDLE;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
      if (goEntF)            bkFull <= 1'b1;
      else if (strb.finRetF) bkFull <= 1'b0;
    end
  end

  assign busy = !idle;

endmodule

// File: rtl/irq_ctx_dp.sv
module irq_ctx_dp
  import irq_ctx_seq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IE_BIT = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobeS       strb,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curPsw,
  input  logic [XLEN-1:0] spIn,
  input  logic [XLEN-1:0] vecPc,
  input  logic [XLEN-1:0] memRdData,
  output logic            memWrEn,
  output logic            memRdEn,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  output logic            pcLoad,
  output logic [XLEN-1:0] pcOut,
  output logic            pswLoad,
  output logic [XLEN-1:0] pswOut,
  output logic            spLoad,
  output logic [XLEN-1:0] spOut
);

  localparam logic [XLEN-1:0] WORD    = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] IE_MASK = {{(XLEN-1){1'b0}}, 1'b1} << IE_BIT;

  logic [XLEN-1:0] ctxPc, ctxPsw, spWork, handler;
  logic [XLEN-1:0] bkPc, bkPsw, popPc, popPsw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxPc   <= '0;
      ctxPsw  <= '0;
      spWork  <= '0;
      handler <= '0;
      bkPc    <= '0;
      bkPsw   <= '0;
      popPc   <= '0;
      popPsw  <= '0;
    end else begin
      if (strb.accept) begin
        ctxPc   <= curPc;
        ctxPsw  <= curPsw;
        spWork  <= spIn;
        handler <= vecPc;
      end
      if (strb.saveBk) begin
        bkPc  <= curPc;
        bkPsw <= curPsw;
      end
      if (strb.capPc)  popPc  <= memRdData;
      if (strb.capPsw) popPsw <= memRdData;
    end
  end

  always_comb begin
    memWrEn   = strb.wrPsw || strb.wrPc;
    memRdEn   = strb.rdPc || strb.rdPsw;
    memAddr   = '0;
    memWrData = '0;
    if (strb.wrPsw) begin
      memAddr   = spWork - WORD;
      memWrData = ctxPsw;
    end else if (strb.wrPc) begin
      memAddr   = spWork - (WORD << 1);
      memWrData = ctxPc;
    end else if (strb.rdPc) begin
      memAddr = spWork;
    end else if (strb.rdPsw) begin
      memAddr = spWork + WORD;
    end
  end

  always_comb begin
    pcLoad  = strb.finEntN || strb.finEntF || strb.finRetN || strb.finRetF;
    pswLoad = pcLoad;
    spLoad  = strb.finEntN || strb.finRetN;
    pcOut   = '0;
    pswOut  = '0;
    spOut   = '0;
    if (strb.finEntN || strb.finEntF) begin
      pcOut  = handler;
      pswOut = ctxPsw & ~IE_MASK;
    end else if (strb.finRetN) begin
      pcOut  = popPc;
      pswOut = popPsw;
    end else if (strb.finRetF) begin
      pcOut  = bkPc;
      pswOut = bkPsw;
    end
    if (strb.finEntN)      spOut = spWork - (WORD << 1);
    else if (strb.finRetN) spOut = spWork + (WORD << 1);
  end

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IE_BIT    = 16,
  parameter int ENT_N_CYC = 7,
  parameter int ENT_F_CYC = 5,
  parameter int RET_N_CYC = 6,
  parameter int RET_F_CYC = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic            irqFast,
  input  logic [XLEN-1:0] vecPc,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curPsw,
  input  logic [XLEN-1:0] spIn,
  input  logic            retNormal,
  input  logic            retFast,
  output logic            memWrEn,
  output logic            memRdEn,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  input  logic [XLEN-1:0] memRdData,
  output logic            pcLoad,
  output logic [XLEN-1:0] pcOut,
  output logic            pswLoad,
  output logic [XLEN-1:0] pswOut,
  output logic            spLoad,
  output logic [XLEN-1:0] spOut,
  output logic            busy
);

  seqStrobeS strb;

  irq_ctx_ctrl #(
    .ENT_N_CYC(ENT_N_CYC),
    .ENT_F_CYC(ENT_F_CYC),
    .RET_N_CYC(RET_N_CYC),
    .RET_F_CYC(RET_F_CYC)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .irqFast  (irqFast),
    .irqEnable(curPsw[IE_BIT]),
    .retNormal(retNormal),
    .retFast  (retFast),
    .strb     (strb),
    .busy     (busy)
  );

  irq_ctx_dp #(
    .XLEN  (XLEN),
    .IE_BIT(IE_BIT)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .curPc    (curPc),
    .curPsw   (curPsw),
    .spIn     (spIn),
    .vecPc    (vecPc),
    .memRdData(memRdData),
    .memWrEn  (memWrEn),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .pcLoad   (pcLoad),
    .pcOut    (pcOut),
    .pswLoad  (pswLoad),
    .pswOut   (pswOut),
    .spLoad   (spLoad),
    .spOut    (spOut)
  );

endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
  parameter int XLEN      = 32,
  parameter int ENT_N_CYC = 7,
  parameter int ENT_F_CYC = 5,
  parameter int RET_N_CYC = 6,
  parameter int RET_F_CYC = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            memWrEn,
  input logic            memRdEn,
  input logic [XLEN-1:0] memAddr,
  input logic            pcLoad,
  input logic            pswLoad,
  input logic            spLoad
);

  localparam int MAX_AB  = (ENT_N_CYC > ENT_F_CYC) ? ENT_N_CYC : ENT_F_CYC;
  localparam int MAX_CD  = (RET_N_CYC > RET_F_CYC) ? RET_N_CYC : RET_F_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
  localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);

  // busy cycles elapsed before the current one
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (!busy) busyCnt <= '0;
    else           busyCnt <= busyCnt + CNT_W'(1);
  end

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memRdEn || pcLoad || pswLoad || spLoad) |-> busy);

  // R3 R4 R7 R8
  lat_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (busyCnt == CNT_W'(ENT_N_CYC - 1) || busyCnt == CNT_W'(ENT_F_CYC - 1) ||
                busyCnt == CNT_W'(RET_N_CYC - 1) || busyCnt == CNT_W'(RET_F_CYC - 1)));

  // R3
  wr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (busyCnt < CNT_W'(2)));

  // R3
  push_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == $past(memAddr) - WORD));

  // R7
  pop_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + WORD));

  // R7
  rd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (busyCnt < CNT_W'(2)) && !memWrEn);

  // R5
  load_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);

  // R3 R7
  sp_with_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spLoad || pswLoad) |-> pcLoad);

endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(
  .XLEN     (XLEN),
  .ENT_N_CYC(ENT_N_CYC),
  .ENT_F_CYC(ENT_F_CYC),
  .RET_N_CYC(RET_N_CYC),
  .RET_F_CYC(RET_F_CYC)
) chkI (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .memWrEn(memWrEn),
  .memRdEn(memRdEn),
  .memAddr(memAddr),
  .pcLoad (pcLoad),
  .pswLoad(pswLoad),
  .spLoad (spLoad)
);

// File: tb/irq_ctx_seq_test.sv
module irq_ctx_seq_test;

  localparam logic [31:0] IE = 32'h0001_0000;

  typedef struct packed {
    bit          busy;
    bit          wr;
    bit          rd;
    bit          pcL;
    bit          pswL;
    bit          spL;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] pc;
    logic [31:0] psw;
    logic [31:0] sp;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0, irqFast = 1'b0, retNormal = 1'b0, retFast = 1'b0;
  logic [31:0] vecPc = '0, curPc = '0, curPsw = '0, spIn = '0, memRdData = '0;
  logic        memWrEn, memRdEn, pcLoad, pswLoad, spLoad, busy;
  logic [31:0] memAddr, memWrData, pcOut, pswOut, spOut;

  irq_ctx_seq uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqFast(irqFast), .vecPc(vecPc),
    .curPc(curPc), .curPsw(curPsw), .spIn(spIn), .retNormal(retNormal),
    .retFast(retFast), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .pcLoad(pcLoad), .pcOut(pcOut),
    .pswLoad(pswLoad), .pswOut(pswOut), .spLoad(spLoad), .spOut(spOut), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string idleTag = "R1";

  // model of the pipeline and memory as seen from the requirements
  logic [31:0] cpuPc = '0, cpuPsw = '0, cpuSp = '0;
  logic [31:0] bkPcM = '0, bkPswM = '0;
  bit          bkFullM = 0;
  logic [31:0] refMem [logic [31:0]];
  logic [31:0] benchMem [logic [31:0]];
  expT         expQ [$];
  string       tagQ [$];

  always @(posedge clk) begin
    if (memWrEn) benchMem[memAddr] = memWrData;
    if (memRdEn && benchMem.exists(memAddr)) memRdData <= benchMem[memAddr];
    else memRdData <= 32'h0;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual %0d cycles, expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic expT busyRec();
    expT r;
    r = '0;
    r.busy = 1;
    return r;
  endfunction

  task automatic push(expT r, string t);
    expQ.push_back(r);
    tagQ.push_back(t);
  endtask

  // R3 normal entry
  task automatic pushEntN();
    expT r;
    logic [31:0] sp = cpuSp;
    r = busyRec(); r.wr = 1; r.addr = sp - 4; r.wdata = cpuPsw; push(r, "R3");
    r = busyRec(); r.wr = 1; r.addr = sp - 8; r.wdata = cpuPc;  push(r, "R3");
    for (int i = 0; i < 4; i++) push(busyRec(), "R3");
    r = busyRec(); r.pcL = 1; r.pc = vecPc; r.pswL = 1; r.psw = cpuPsw & ~IE;
    r.spL = 1; r.sp = sp - 8; push(r, "R3");
    refMem[sp - 4] = cpuPsw;
    refMem[sp - 8] = cpuPc;
  endtask

  // R4 fast entry
  task automatic pushEntF();
    expT r;
    for (int i = 0; i < 4; i++) push(busyRec(), "R4");
    r = busyRec(); r.pcL = 1; r.pc = vecPc; r.pswL = 1; r.psw = cpuPsw & ~IE;
    push(r, "R4");
    bkPcM = cpuPc; bkPswM = cpuPsw; bkFullM = 1;
  endtask

  // R7 normal return
  task automatic pushRetN();
    expT r;
    logic [31:0] sp = cpuSp;
    r = busyRec(); r.rd = 1; r.addr = sp;     push(r, "R7");
    r = busyRec(); r.rd = 1; r.addr = sp + 4; push(r, "R7");
    for (int i = 0; i < 3; i++) push(busyRec(), "R7");
    r = busyRec(); r.pcL = 1; r.pc = refMem[sp]; r.pswL = 1; r.psw = refMem[sp + 4];
    r.spL = 1; r.sp = sp + 8; push(r, "R7");
  endtask

  // R8 fast return
  task automatic pushRetF();
    expT r;
    for (int i = 0; i < 2; i++) push(busyRec(), "R8");
    r = busyRec(); r.pcL = 1; r.pc = bkPcM; r.pswL = 1; r.psw = bkPswM; push(r, "R8");
    bkFullM = 0;
  endtask

  task automatic step(input bit irq, input bit fast, input bit rn, input bit rf);
    expT   e;
    string t, pt;
    bit    idleNow;
    @(negedge clk);
    idleNow = (expQ.size() == 0);
    if (!idleNow) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
    end else begin
      e = '0;
      t = idleTag;
    end
    pt = (t == "R3" || t == "R4") ? "R5" : t;
    chk(t, "busy", {31'b0, busy}, {31'b0, e.busy});
    chk(t, "memWrEn", {31'b0, memWrEn}, {31'b0, e.wr});
    chk(t, "memRdEn", {31'b0, memRdEn}, {31'b0, e.rd});
    if (e.wr || e.rd) chk(t, "memAddr", memAddr, e.addr);
    if (e.wr) chk(t, "memWrData", memWrData, e.wdata);
    chk(t, "pcLoad", {31'b0, pcLoad}, {31'b0, e.pcL});
    if (e.pcL) chk(t, "pcOut", pcOut, e.pc);
    chk(pt, "pswLoad", {31'b0, pswLoad}, {31'b0, e.pswL});
    if (e.pswL) chk(pt, "pswOut", pswOut, e.psw);
    chk(t, "spLoad", {31'b0, spLoad}, {31'b0, e.spL});
    if (e.spL) chk(t, "spOut", spOut, e.sp);
    if (e.pcL) cpuPc = e.pc;
    if (e.pswL) cpuPsw = e.psw;
    if (e.spL) cpuSp = e.sp;
    irqReq = irq; irqFast = fast; retNormal = rn; retFast = rf;
    curPc = cpuPc; curPsw = cpuPsw; spIn = cpuSp;
    if (idleNow) begin
      if (rf && bkFullM) pushRetF();           // R9 order
      else if (rn) pushRetN();
      else if (irq && (cpuPsw & IE) != 0) begin
        if (fast && !bkFullM) pushEntF();
        else if (!fast) pushEntN();
      end
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic preload(logic [31:0] a, logic [31:0] d);
    refMem[a] = d;
    benchMem[a] = d;
  endtask

  initial begin
    cpuPc = 32'h0000_0100; cpuPsw = 32'h0; cpuSp = 32'h0000_8000;
    vecPc = 32'h4000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and idle quiet
    idleTag = "R1";
    repeat (3) step(0, 0, 0, 0);

    // R2 enable bit clear: requests ignored
    idleTag = "R2";
    repeat (3) step(1, 0, 0, 0);
    repeat (2) step(1, 1, 0, 0);
    step(0, 0, 0, 0);

    // R3 R5 normal entry
    cpuPsw = 32'h0001_00A5; cpuPc = 32'h0000_1230;
    step(1, 0, 0, 0);
    drain();

    // R7 normal return from the frame just pushed
    cpuPc = 32'h4000_0040;
    step(0, 0, 1, 0);
    drain();

    // R10 commands during busy are dropped
    idleTag = "R10";
    cpuPc = 32'h0000_2000;
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    step(1, 0, 0, 0);
    step(0, 0, 1, 1);
    drain();
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    drain();

    // R4 R5 fast entry
    idleTag = "R4";
    cpuPc = 32'h0000_3000; cpuPsw = 32'h0001_0033; vecPc = 32'h5000_0000;
    step(1, 1, 0, 0);
    drain();

    // R6 fast refused while backup is occupied, normal still taken
    idleTag = "R6";
    cpuPsw = cpuPsw | IE;
    repeat (6) step(1, 1, 0, 0);
    vecPc = 32'h6000_0000;
    step(1, 0, 0, 0);
    drain();
    step(0, 0, 1, 0);
    drain();

    // R9 fast return beats a held request; R2 request taken when idle
    idleTag = "R9";
    step(1, 0, 0, 1);
    while (expQ.size() != 0) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    drain();

    // R9 invalid fast return does not block a normal return
    step(0, 0, 1, 1);
    drain();

    // R8 fast return with empty backup is ignored
    idleTag = "R8";
    step(0, 0, 0, 1);
    repeat (2) step(0, 0, 0, 0);

    // R7 preloaded frame at another stack position
    cpuSp = 32'h0000_9000;
    preload(32'h0000_9000, 32'hCAFE_0000);
    preload(32'h0000_9004, 32'hFFFF_BEEF);
    step(0, 0, 1, 0);
    drain();

    // R5 all-ones PSW through fast entry and R8 return
    cpuPc = 32'h0000_7770; cpuPsw = 32'hFFFF_FFFF;
    step(1, 1, 0, 0);
    drain();
    step(0, 0, 0, 1);
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule